// File: doc/BRIEF.md
# Alert Class Escalation Controller

This block manages a single class of classified security alerts. Each accepted alert strobe raises a saturating accumulator. The block starts a timed escalation sequence when the accumulator rises above a programmed threshold, or when a programmed interrupt deadline runs out after the first alert. The sequence moves through four phases, each with its own programmed length in clock cycles, and then holds in a terminal state until it is cleared.

Four escalation outputs can each be enabled and pointed at one of the four phases. Several outputs may share a phase, and a phase that drives no output works as a plain wait interval. A crashdump pulse marks entry into one selected phase. A clear request returns the class to idle. Two things can refuse a clear: a control bit that blocks clearing once escalation has begun, and a one-way clear-enable that, once dropped, blocks clearing until reset.

Top module: `esc_class_ctrl`

## Requirements
- R1: After a synchronous reset the state is Idle, and the accumulator, the cycle counter, all escalation outputs and the crashdump pulse are 0.
- R2: Each clock cycle with `alert_i` high and `cfg_en` high adds 1 to the accumulator. The accumulator saturates at 0xFFFF.
- R3: While `cfg_en` is low, alert strobes leave the accumulator unchanged and the state stays Idle.
- R4: Escalation starts only when the accumulator is strictly greater than `cfg_thresh`; a value equal to it does not start it. The state becomes Phase0 one cycle after the accumulator first exceeds the threshold, from Idle or from Timeout.
- R5: With `cfg_deadline` nonzero, an accepted alert in Idle moves the state to Timeout at the same clock edge. Timeout lasts `cfg_deadline` cycles and is then followed by Phase0. With `cfg_deadline` = 0 the Timeout state is never entered.
- R6: The phases run in the order Phase0, Phase1, Phase2, Phase3 and then Terminal. Phase k lasts `cfg_phase_cyc[k]` cycles, and a length of 0 counts as 1. Terminal holds until a clear is accepted.
- R7: `state_o` is encoded as Idle=0, Timeout=1, Terminal=3 and Phase k=4+k. The value 2 never appears.
- R8: `esc_o[i]` is high exactly in the cycles where `state_o` is the phase selected by `cfg_sig_map[i]` and `cfg_sig_en[i]` is 1.
- R9: `crashdump_o` is high for exactly the first cycle of the phase selected by `cfg_crash_phase`.
- R10: `esc_cnt_o` is 0 in the first cycle of Timeout and of each phase, and it rises by 1 each cycle after that. It is 0 in Idle and in Terminal.
- R11: An accepted `clr_i` sets the state to Idle and sets the accumulator, the cycle counter and `esc_o` to 0 at the next clock edge. A clear has priority over an alert in the same cycle.
- R12: With `cfg_lock_esc` = 1, `clr_i` is ignored in the phase and Terminal states. It is still accepted in Idle and in Timeout.
- R13: A pulse on `clr_wen_drop_i` blocks all later clear requests until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Class enable |
| cfg_lock_esc | input | 1 | Refuse clears once escalation has begun |
| cfg_thresh | input | 16 | Accumulator threshold |
| cfg_deadline | input | 32 | Interrupt deadline in cycles (0 disables Timeout) |
| cfg_phase_cyc | input | 4x32 | Length of each phase in cycles |
| cfg_sig_en | input | 4 | Enable for each escalation output |
| cfg_sig_map | input | 4x2 | Phase selected for each escalation output |
| cfg_crash_phase | input | 2 | Phase whose entry raises the crashdump pulse |
| alert_i | input | 1 | Classified alert strobe, one count per cycle |
| clr_i | input | 1 | Clear request |
| clr_wen_drop_i | input | 1 | One-way drop of the clear enable |
| esc_o | output | 4 | Escalation outputs |
| state_o | output | 3 | Current class state |
| esc_cnt_o | output | 32 | Cycle count in the current timed state |
| accum_o | output | 16 | Accumulator value |
| crashdump_o | output | 1 | Crashdump capture pulse |

## Verification
All outputs are registered from the same next-state value, so a wrong state decision shows on `state_o`, `esc_o` and `esc_cnt_o` in the very cycle after the edge that made it. A miscounted phase length appears as a state change one cycle early or one cycle late against a cycle-exact expected sequence. A fault in the accumulator shows on `accum_o` at once, and it also moves the Phase0 entry cycle away from the one-cycle-after-exceed point. A clear that is wrongly accepted or wrongly refused shows on the next cycle as Idle, or as a state other than Idle, together with the accumulator value.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int PH_N = 4;
  localparam int PH_W = $clog2(PH_N);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_FINAL = 3'd3,
    ST_P0    = 3'd4,
    ST_P1    = 3'd5,
    ST_P2    = 3'd6,
    ST_P3    = 3'd7
  } esc_state_e;

  function automatic esc_state_e phase_state(input logic [PH_W-1:0] idx);
    return esc_state_e'({1'b1, idx});
  endfunction

  function automatic logic is_escalating(input esc_state_e s);
    return (s == ST_FINAL) || s[2];
  endfunction
endpackage

// File: rtl/esc_accum.sv
module esc_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [ACC_W-1:0] thresh,
  output logic [ACC_W-1:0] acc_o,
  output logic             over_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (inc && (acc_q != ACC_MAX)) begin
      acc_q <= acc_q + ACC_W'(1);
    end
  end

  assign acc_o  = acc_q;
  assign over_o = (acc_q > thresh);
endmodule

// File: rtl/esc_fsm.sv
module esc_fsm
  import esc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       alert,
  input  logic                       over,
  input  logic                       clr_ok,
  input  logic [CNT_W-1:0]           deadline,
  input  logic [PH_N-1:0][CNT_W-1:0] phase_cyc,
  output esc_state_e                 st_q_o,
  output esc_state_e                 st_d_o,
  output logic [CNT_W-1:0]           cnt_o
);
  esc_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_idx;
  logic             wait_done, ph_done;

  // A limit of 0 is treated as 1: the state still lasts one cycle.
  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] lim);
    return ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, lim};
  endfunction

  assign ph_idx    = st_q[PH_W-1:0];
  assign wait_done = reached(cnt_q, deadline);
  assign ph_done   = reached(cnt_q, phase_cyc[ph_idx]);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clr_ok) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (en && over) begin
            st_d = ST_P0;
          end else if (en && alert && (deadline != '0)) begin
            st_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (over || wait_done) begin
            st_d  = ST_P0;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_P0, ST_P1, ST_P2, ST_P3: begin
          if (ph_done) begin
            st_d  = (ph_idx == PH_W'(PH_N-1)) ? ST_FINAL
                                              : phase_state(ph_idx + PH_W'(1));
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_FINAL: cnt_d = '0;
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_q_o = st_q;
  assign st_d_o = st_d;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/esc_sigmap.sv
module esc_sigmap
  import esc_pkg::*;
#(
  parameter int NUM_SIG = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  esc_state_e                     st_q,
  input  esc_state_e                     st_d,
  input  logic [NUM_SIG-1:0]             sig_en,
  input  logic [NUM_SIG-1:0][PH_W-1:0]   sig_map,
  input  logic [PH_W-1:0]                crash_sel,
  output logic [NUM_SIG-1:0]             esc_o,
  output logic                           crash_o
);
  logic [NUM_SIG-1:0] hit;
  logic               crash_d;

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
    assign hit[g] = sig_en[g] && (st_d == phase_state(sig_map[g]));
  end

  assign crash_d = (st_d != st_q) && (st_d == phase_state(crash_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      esc_o   <= '0;
      crash_o <= 1'b0;
    end else begin
      esc_o   <= hit;
      crash_o <= crash_d;
    end
  end
endmodule

// File: rtl/esc_class_ctrl.sv
module esc_class_ctrl
  import esc_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int CNT_W   = 32,
  parameter int NUM_SIG = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_en,
  input  logic                         cfg_lock_esc,
  input  logic [ACC_W-1:0]             cfg_thresh,
  input  logic [CNT_W-1:0]             cfg_deadline,
  input  logic [PH_N-1:0][CNT_W-1:0]   cfg_phase_cyc,
  input  logic [NUM_SIG-1:0]           cfg_sig_en,
  input  logic [NUM_SIG-1:0][PH_W-1:0] cfg_sig_map,
  input  logic [PH_W-1:0]              cfg_crash_phase,
  input  logic                         alert_i,
  input  logic                         clr_i,
  input  logic                         clr_wen_drop_i,
  output logic [NUM_SIG-1:0]           esc_o,
  output logic [2:0]                   state_o,
  output logic [CNT_W-1:0]             esc_cnt_o,
  output logic [ACC_W-1:0]             accum_o,
  output logic                         crashdump_o
);
  esc_state_e st_q, st_d;
  logic       clr_wen_q;
  logic       clr_ok;
  logic       over;

  // One-way clear enable: only reset sets it again.
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_wen_q <= 1'b1;
    end else if (clr_wen_drop_i) begin
      clr_wen_q <= 1'b0;
    end
  end

  assign clr_ok = clr_i && clr_wen_q && !(cfg_lock_esc && is_escalating(st_q));

  esc_accum #(.ACC_W(ACC_W)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_ok),
    .inc    (cfg_en && alert_i),
    .thresh (cfg_thresh),
    .acc_o  (accum_o),
    .over_o (over)
  );

  esc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_en),
    .alert     (alert_i),
    .over      (over),
    .clr_ok    (clr_ok),
    .deadline  (cfg_deadline),
    .phase_cyc (cfg_phase_cyc),
    .st_q_o    (st_q),
    .st_d_o    (st_d),
    .cnt_o     (esc_cnt_o)
  );

  esc_sigmap #(.NUM_SIG(NUM_SIG)) u_map (
    .clk       (clk),
    .rst       (rst),
    .st_q      (st_q),
    .st_d      (st_d),
    .sig_en    (cfg_sig_en),
    .sig_map   (cfg_sig_map),
    .crash_sel (cfg_crash_phase),
    .esc_o     (esc_o),
    .crash_o   (crashdump_o)
  );

  assign state_o = st_q;
endmodule

// File: rtl/esc_class_ctrl_chk.sv
module esc_class_ctrl_chk #(
  parameter int ACC_W   = 16,
  parameter int NUM_SIG = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_en,
  input logic               cfg_lock_esc,
  input logic               clr_wen,
  input logic [2:0]         state_o,
  input logic [NUM_SIG-1:0] esc_o,
  input logic [ACC_W-1:0]   accum_o,
  input logic               crashdump_o
);
  // R7
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    state_o != 3'd2);

  // R2
  accum_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (accum_o >= $past(accum_o)) || (accum_o == '0));

  // R3
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && state_o == 3'd0) |=> state_o == 3'd0);

  // R6
  terminal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3) |=> (state_o == 3'd3 || state_o == 3'd0));

  // R8
  esc_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (esc_o != '0) |-> state_o[2]);

  // R9
  crash_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    crashdump_o |-> (state_o[2] && state_o != $past(state_o)));

  // R12
  lock_esc_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_lock_esc && (state_o[2] || state_o == 3'd3)) |=> state_o != 3'd0);

  // R13
  clr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_wen && state_o != 3'd0) |=> state_o != 3'd0);
endmodule

bind esc_class_ctrl esc_class_ctrl_chk #(.ACC_W(ACC_W), .NUM_SIG(NUM_SIG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_en       (cfg_en),
  .cfg_lock_esc (cfg_lock_esc),
  .clr_wen      (clr_wen_q),
  .state_o      (state_o),
  .esc_o        (esc_o),
  .accum_o      (accum_o),
  .crashdump_o  (crashdump_o)
);

// File: tb/esc_class_ctrl_test.sv
`timescale 1ns/1ps
module esc_class_ctrl_test;
  localparam int ACC_W = 16;
  localparam int CNT_W = 32;
  localparam int NSIG  = 4;
  localparam realtime HALF = 4.0;

  logic                     clk = 1'b0;
  logic                     rst;
  logic                     cfg_en, cfg_lock_esc;
  logic [ACC_W-1:0]         cfg_thresh;
  logic [CNT_W-1:0]         cfg_deadline;
  logic [3:0][CNT_W-1:0]    cfg_phase_cyc;
  logic [NSIG-1:0]          cfg_sig_en;
  logic [NSIG-1:0][1:0]     cfg_sig_map;
  logic [1:0]               cfg_crash_phase;
  logic                     alert_i, clr_i, clr_wen_drop_i;
  logic [NSIG-1:0]          esc_o;
  logic [2:0]               state_o;
  logic [CNT_W-1:0]         esc_cnt_o;
  logic [ACC_W-1:0]         accum_o;
  logic                     crashdump_o;

  int checks = 0;
  int fails  = 0;

  always #(HALF) clk = ~clk;

  esc_class_ctrl uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_lock_esc(cfg_lock_esc),
    .cfg_thresh(cfg_thresh), .cfg_deadline(cfg_deadline),
    .cfg_phase_cyc(cfg_phase_cyc), .cfg_sig_en(cfg_sig_en),
    .cfg_sig_map(cfg_sig_map), .cfg_crash_phase(cfg_crash_phase),
    .alert_i(alert_i), .clr_i(clr_i), .clr_wen_drop_i(clr_wen_drop_i),
    .esc_o(esc_o), .state_o(state_o), .esc_cnt_o(esc_cnt_o),
    .accum_o(accum_o), .crashdump_o(crashdump_o)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    alert_i = 1'b0; clr_i = 1'b0; clr_wen_drop_i = 1'b0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", 32'(state_o), 0);
    check("R1 accum", 32'(accum_o), 0);
    check("R1 cnt", esc_cnt_o, 0);
    check("R1 esc", 32'(esc_o), 0);
    check("R1 crash", 32'(crashdump_o), 0);
  endtask

  task automatic t_accum_sat();
    do_reset();
    cfg_thresh = 16'hFFFF; cfg_deadline = 0;
    alert_i = 1'b1; tick(5); alert_i = 1'b0;
    check("R2 count5", 32'(accum_o), 5);
    tick(2);
    check("R2 hold", 32'(accum_o), 5);
    alert_i = 1'b1; tick(65540); alert_i = 1'b0;
    check("R2 saturate", 32'(accum_o), 32'hFFFF);
    check("R4 no escalate at max", 32'(state_o), 0);
    clr_i = 1'b1; alert_i = 1'b1; tick(); clr_i = 1'b0; alert_i = 1'b0;
    check("R11 clear wins over alert", 32'(accum_o), 0);
  endtask

  task automatic t_enable_off();
    do_reset();
    cfg_en = 1'b0; cfg_thresh = 0; cfg_deadline = 5;
    alert_i = 1'b1; tick(5); alert_i = 1'b0; tick();
    check("R3 accum", 32'(accum_o), 0);
    check("R3 state", 32'(state_o), 0);
    cfg_en = 1'b1;
  endtask

  task automatic t_escalate();
    logic [3:0] exp_esc [4];
    int dur [4];
    exp_esc[0] = 4'b0000; exp_esc[1] = 4'b0011;
    exp_esc[2] = 4'b0000; exp_esc[3] = 4'b1000;
    dur[0] = 3; dur[1] = 2; dur[2] = 1; dur[3] = 4;
    do_reset();
    cfg_thresh = 2; cfg_deadline = 0;
    cfg_phase_cyc[0] = 3; cfg_phase_cyc[1] = 2;
    cfg_phase_cyc[2] = 0; cfg_phase_cyc[3] = 4;
    cfg_sig_en = 4'b1011;
    cfg_sig_map[0] = 2'd1; cfg_sig_map[1] = 2'd1;
    cfg_sig_map[2] = 2'd0; cfg_sig_map[3] = 2'd3;
    cfg_crash_phase = 2'd2;
    alert_i = 1'b1; tick(2); alert_i = 1'b0;
    check("R5 no timeout with deadline 0", 32'(state_o), 0);
    tick(2);
    check("R4 equal does not trigger", 32'(state_o), 0);
    alert_i = 1'b1; tick(); alert_i = 1'b0;
    check("R4 accum above", 32'(accum_o), 3);
    check("R4 one cycle later", 32'(state_o), 0);
    tick();
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < dur[k]; c++) begin
        check($sformatf("R6 R7 phase%0d state", k), 32'(state_o), 32'(4 + k));
        check($sformatf("R10 phase%0d cnt", k), esc_cnt_o, 32'(c));
        check($sformatf("R8 phase%0d esc", k), 32'(esc_o), 32'(exp_esc[k]));
        check($sformatf("R9 phase%0d crash", k), 32'(crashdump_o),
              32'((k == 2) && (c == 0)));
        tick();
      end
    end
    check("R6 terminal", 32'(state_o), 3);
    tick(5);
    check("R6 terminal hold", 32'(state_o), 3);
    check("R10 terminal cnt", esc_cnt_o, 0);
    check("R8 terminal esc", 32'(esc_o), 0);
    cfg_lock_esc = 1'b0;
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    check("R11 state", 32'(state_o), 0);
    check("R11 accum", 32'(accum_o), 0);
    check("R11 esc", 32'(esc_o), 0);
    check("R11 cnt", esc_cnt_o, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    cfg_thresh = 10; cfg_deadline = 4; cfg_phase_cyc[0] = 3;
    alert_i = 1'b1; tick(); alert_i = 1'b0;
    check("R5 enter timeout", 32'(state_o), 1);
    check("R10 timeout cnt0", esc_cnt_o, 0);
    tick(3);
    check("R5 still timeout", 32'(state_o), 1);
    check("R10 timeout cnt3", esc_cnt_o, 3);
    tick();
    check("R5 deadline to phase0", 32'(state_o), 4);
    cfg_lock_esc = 1'b1;
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    check("R12 clear refused state", 32'(state_o), 4);
    check("R12 clear refused cnt", esc_cnt_o, 1);
    check("R12 clear refused accum", 32'(accum_o), 1);
    // clear during Timeout is still accepted with the lock bit set
    do_reset();
    alert_i = 1'b1; tick(); alert_i = 1'b0;
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    check("R12 timeout clear state", 32'(state_o), 0);
    check("R11 timeout clear accum", 32'(accum_o), 0);
    cfg_lock_esc = 1'b0;
  endtask

  task automatic t_timeout_over();
    do_reset();
    cfg_thresh = 1; cfg_deadline = 100;
    alert_i = 1'b1; tick(2); alert_i = 1'b0;
    check("R4 in timeout", 32'(state_o), 1);
    tick();
    check("R4 over from timeout", 32'(state_o), 4);
  endtask

  task automatic t_clr_disable();
    do_reset();
    cfg_thresh = 10; cfg_deadline = 4;
    clr_wen_drop_i = 1'b1; tick(); clr_wen_drop_i = 1'b0;
    alert_i = 1'b1; tick(); alert_i = 1'b0;
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    check("R13 blocked state", 32'(state_o), 1);
    check("R13 blocked accum", 32'(accum_o), 1);
    do_reset();
    alert_i = 1'b1; tick(); alert_i = 1'b0;
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    check("R13 restored by reset", 32'(state_o), 0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_en = 1'b1; cfg_lock_esc = 1'b0;
    cfg_thresh = '0; cfg_deadline = '0;
    cfg_phase_cyc = '0; cfg_sig_en = '0; cfg_sig_map = '0;
    cfg_crash_phase = '0;
    alert_i = 1'b0; clr_i = 1'b0; clr_wen_drop_i = 1'b0;
    t_reset();
    t_enable_off();
    t_escalate();
    t_timeout();
    t_timeout_over();
    t_clr_disable();
    t_accum_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule